// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block is a management-interface master that reaches external Ethernet PHYs over the two-wire MDC/MDIO bus. Software programs it through a small register port with four 32-bit words: configuration/status, control, address and data. A single frame engine serves both IEEE 802.3 Clause 22 and Clause 45 access, chosen by a mode bit.

In Clause 45 mode an indirect access takes two steps. Software first writes the register address word, which sends an address frame to the selected port and device. It then writes the data word, which sends a write frame, or sets the read bit in the control word, which sends a read frame. In Clause 22 mode the device field carries the register number, and only the data and control words start frames. Every frame opens with a 32-bit preamble of ones. MDIO is released while the PHY turns the bus around and returns read data. MDC runs only while a frame is in flight, and its rate comes from a programmable divider.

Register word offsets: 0 configuration/status, 1 control, 2 address, 3 data.

Top module: `mdio_master`

## Requirements
- R1: After reset all four register words read zero, MDC is low and MDIO is not driven.
- R2: In Clause 22 mode (configuration bit 0 clear), a data-word write sends 32 ones, start 01, opcode 01, the 5-bit port (control bits 12:8), the 5-bit register number (control bits 4:0), turnaround 10 and the 16 data bits. Bits go out MSB first, one per MDC period, and are sampled by the PHY on the rising edge of MDC.
- R3: Writing the control word with bit 15 set sends a read frame (Clause 22 opcode 10). The master releases MDIO from the first turnaround bit to the end of the frame, and the 16 bits captured on the rising edges of MDC appear in data-word bits 15:0 once the frame ends.
- R4: In Clause 45 mode (configuration bit 0 set), frames use start 00. An address-word write sends opcode 00 with the address as payload, a data-word write sends opcode 01, and a read sends opcode 11.
- R5: In Clause 22 mode an address-word write stores the value but starts no frame.
- R6: Status bit 2 (busy) is set from the clock edge that accepts a launch until the last MDC falling edge of that frame. Writes to the control, address or data word while busy is set leave those words unchanged and start nothing. This includes a write in the cycle of the final MDC edge.
- R7: If the PHY's second turnaround bit samples as 1, status bit 3 is set. With the bus left pulled up, the data word then reads 0xFFFF. The flag clears when the next read is launched.
- R8: Configuration bits 31:16 give the half-period of MDC in system clocks (period = 2 x value). A value of 0 holds MDC low and stalls a pending frame until a nonzero value is written.
- R9: With configuration bit 1 set, MDIO changes in the same system clock as MDC falls. With it clear, MDIO changes one system clock later.
- R10: While no frame is in flight, MDC stays low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock toward the PHYs |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The risky overlap is a software launch that arrives in the same system clock as the final MDC falling edge of the frame in flight. In that cycle busy is still high, so the write must be dropped, and the next cycle must find the engine idle. The bench writes the data word in every cycle from the last MDC rising edge through the completion edge. It then checks that busy has cleared, that the data word still holds the original payload, and that no extra frame appears on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = 6;

    localparam logic [IDX_W-1:0] IDX_TA_FIRST = 6'd46;
    localparam logic [IDX_W-1:0] IDX_TA_CHECK = 6'd47;
    localparam logic [IDX_W-1:0] IDX_DATA0    = 6'd48;
    localparam logic [IDX_W-1:0] IDX_LAST     = 6'd63;

    localparam logic [1:0] RA_CFG  = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_ADDR = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    localparam int CFG_C45     = 0;
    localparam int CFG_NEG     = 1;
    localparam int CFG_BUSY    = 2;
    localparam int CFG_RDERR   = 3;
    localparam int CFG_DIV_LSB = 16;
    localparam int CTRL_PORT   = 8;
    localparam int CTRL_RD     = 15;

    typedef enum logic [1:0] {
        KIND_ADDR  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_READ  = 2'd2
    } kind_e;

    typedef struct packed {
        logic        c45;
        kind_e       kind;
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] payload;
    } req_t;

    // start code followed by opcode
    function automatic logic [3:0] lead_code(req_t r);
        if (r.c45) begin
            case (r.kind)
                KIND_ADDR:  return 4'b0000;
                KIND_WRITE: return 4'b0001;
                default:    return 4'b0011;
            endcase
        end
        if (r.kind == KIND_READ) return 4'b0110;
        return 4'b0101;
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_of(req_t r);
        logic [15:0] tail;
        tail = (r.kind == KIND_READ) ? 16'hFFFF : r.payload;
        return {32'hFFFF_FFFF, lead_code(r), r.port, r.dev, 2'b10, tail};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = run && (div != '0) && (cnt >= div - 1'b1);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else if (div != '0) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  start_rd,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  mdio_i,
    output logic                  busy,
    output logic                  rd_frame,
    output logic [IDX_W-1:0]      bitcnt,
    output logic                  sdo,
    output logic                  sdo_en,
    output logic                  rd_err,
    output logic [15:0]           rd_data,
    output logic                  rd_done
);
    logic [FRAME_BITS-1:0] sh;

    assign sdo     = sh[FRAME_BITS-1];
    assign sdo_en  = busy && !(rd_frame && (bitcnt >= IDX_TA_FIRST));
    assign rd_done = busy && fall && rd_frame && (bitcnt == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            bitcnt   <= '0;
            busy     <= 1'b0;
            rd_frame <= 1'b0;
            rd_err   <= 1'b0;
            rd_data  <= '0;
        end else if (start && !busy) begin
            sh       <= frame;
            bitcnt   <= '0;
            busy     <= 1'b1;
            rd_frame <= start_rd;
            if (start_rd) rd_err <= 1'b0;
        end else if (busy) begin
            if (rise && rd_frame) begin
                if (bitcnt == IDX_TA_CHECK) rd_err <= mdio_i;
                if (bitcnt >= IDX_DATA0)    rd_data <= {rd_data[14:0], mdio_i};
            end
            if (fall) begin
                if (bitcnt == IDX_LAST) begin
                    busy <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                    sh     <= {sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  busy,
    input  logic                  rd_err,
    input  logic                  rd_done,
    input  logic [15:0]           rd_data,
    output logic                  c45,
    output logic                  neg,
    output logic [DIV_W-1:0]      div,
    output logic                  start,
    output logic                  start_rd,
    output logic [FRAME_BITS-1:0] frame
);
    logic [4:0]  port_q, dev_q;
    logic [15:0] addr_q, data_q;
    req_t        req;
    logic        wr_ok;

    assign wr_ok = bus_wr && !busy;

    always_comb begin
        req = '{c45: c45, kind: KIND_WRITE, port: port_q, dev: dev_q,
                payload: bus_wdata[15:0]};
        start = 1'b0;
        if (wr_ok) begin
            case (bus_addr)
                RA_CTRL: if (bus_wdata[CTRL_RD]) begin
                    start    = 1'b1;
                    req.kind = KIND_READ;
                    req.port = bus_wdata[CTRL_PORT +: 5];
                    req.dev  = bus_wdata[4:0];
                end
                RA_ADDR: if (c45) begin
                    start    = 1'b1;
                    req.kind = KIND_ADDR;
                end
                RA_DATA: start = 1'b1;
                default: ;
            endcase
        end
        start_rd = start && (req.kind == KIND_READ);
        frame    = frame_of(req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c45    <= 1'b0;
            neg    <= 1'b0;
            div    <= '0;
            port_q <= '0;
            dev_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (bus_wr && bus_addr == RA_CFG) begin
                c45 <= bus_wdata[CFG_C45];
                neg <= bus_wdata[CFG_NEG];
                div <= bus_wdata[CFG_DIV_LSB +: DIV_W];
            end
            if (wr_ok && bus_addr == RA_CTRL) begin
                port_q <= bus_wdata[CTRL_PORT +: 5];
                dev_q  <= bus_wdata[4:0];
            end
            if (wr_ok && bus_addr == RA_ADDR) addr_q <= bus_wdata[15:0];
            if (wr_ok && bus_addr == RA_DATA) data_q <= bus_wdata[15:0];
            if (rd_done)                      data_q <= rd_data;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CFG: begin
                bus_rdata[CFG_DIV_LSB +: DIV_W] = div;
                bus_rdata[CFG_RDERR] = rd_err;
                bus_rdata[CFG_BUSY]  = busy;
                bus_rdata[CFG_NEG]   = neg;
                bus_rdata[CFG_C45]   = c45;
            end
            RA_CTRL: begin
                bus_rdata[CTRL_PORT +: 5] = port_q;
                bus_rdata[4:0]            = dev_q;
            end
            RA_ADDR: bus_rdata[15:0] = addr_q;
            default: bus_rdata[15:0] = data_q;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic                  c45, neg, start, start_rd;
    logic [DIV_W-1:0]      div;
    logic [FRAME_BITS-1:0] frame;
    logic                  busy, rd_frame, rd_err, rd_done;
    logic [IDX_W-1:0]      bitcnt;
    logic [15:0]           rd_data;
    logic                  rise, fall, sdo, sdo_en, sdo_q, sdo_en_q;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .rd_err(rd_err), .rd_done(rd_done), .rd_data(rd_data), .c45(c45),
        .neg(neg), .div(div), .start(start), .start_rd(start_rd), .frame(frame)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .run(busy), .div(div),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdio_shifter u_shift (
        .clk(clk), .rst(rst), .start(start), .start_rd(start_rd),
        .frame(frame), .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .busy(busy), .rd_frame(rd_frame), .bitcnt(bitcnt), .sdo(sdo),
        .sdo_en(sdo_en), .rd_err(rd_err), .rd_data(rd_data), .rd_done(rd_done)
    );

    // late-launch option: hold MDIO one extra system clock after MDC falls
    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q    <= 1'b0;
            sdo_en_q <= 1'b0;
        end else begin
            sdo_q    <= sdo;
            sdo_en_q <= sdo_en;
        end
    end

    assign mdio_o  = neg ? sdo    : sdo_q;
    assign mdio_oe = neg ? sdo_en : sdo_en_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             start,
    input logic             mdc,
    input logic             mdio_oe,
    input logic [DIV_W-1:0] div,
    input logic             rd_frame,
    input logic [5:0]       bitcnt,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_rdata
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (!mdc && !mdio_oe)); // R10

    AST_DIV_ZERO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |=> $stable(mdc)); // R8

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_frame && bitcnt >= 6'd47) |-> !mdio_oe); // R3

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R6

    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_wr && bus_addr == 2'd2) |=>
        (bus_addr != 2'd2 || bus_rdata == $past(bus_rdata))); // R6
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .start(start), .mdc(mdc),
    .mdio_oe(mdio_oe), .div(div), .rd_frame(rd_frame), .bitcnt(bitcnt),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_i, mdio_o, mdio_oe;
    logic        phy_en = 1'b0, phy_bit = 1'b1;

    always #2 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // pulled-up shared line
    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    typedef struct {
        logic [63:0] bits;
        bit          rd;
        bit          resp;
        logic [15:0] rdv;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int vectors = 0, miscompares = 0;
    int r = 0, frames_done = 0;
    logic [63:0] got, en;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit c45, input int kind, input logic [4:0] port,
                                       input logic [4:0] dev, input logic [15:0] pay);
        logic [3:0] lead;
        if (c45) lead = (kind == 0) ? 4'b0000 : (kind == 1) ? 4'b0001 : 4'b0011;
        else     lead = (kind == 2) ? 4'b0110 : 4'b0101;
        return {32'hFFFF_FFFF, lead, port, dev, 2'b10, pay};
    endfunction

    task automatic push(input logic [63:0] bits, input bit rd, input bit resp,
                        input logic [15:0] rdv, input string tag);
        exp_t e;
        e.bits = bits; e.rd = rd; e.resp = resp; e.rdv = rdv; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: one bit per rising MDC edge
    always @(posedge mdc) begin
        got[63-r] = mdio_o;
        en[63-r]  = mdio_oe;
        r++;
        if (r == 64) begin
            bit ok;
            r = 0;
            frames_done++;
            if (q.size() == 0) begin
                chk(1'b0, "R5 unexpected frame", got, 64'h0);
            end else begin
                cur = q.pop_front();
                ok = 1'b1;
                for (int i = 0; i < 64; i++) begin
                    if (cur.rd && i >= 46) ok = ok && !en[63-i];
                    else ok = ok && en[63-i] && (got[63-i] == cur.bits[63-i]);
                end
                chk(ok, cur.tag, got, cur.bits);
            end
        end
    end

    // PHY responder: drives on falling MDC
    always @(negedge mdc) begin
        phy_en = 1'b0;
        if (q.size() > 0 && q[0].rd) begin
            if (r == 47) begin
                phy_en = q[0].resp; phy_bit = 1'b0;
            end else if (r >= 48 && r <= 63) begin
                phy_en = q[0].resp; phy_bit = q[0].rdv[63-r];
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        do begin
            rd(2'd0, s);
            n++;
        end while (s[2] && n < 5000);
    endtask

    // R9: MDIO timing relative to the 32nd MDC fall (start of start code, a 0 bit)
    task automatic edge_check(input bit neg, input string tag);
        logic prev, v0, v1;
        int falls = 0, guard = 0;
        prev = mdc;
        while (falls < 32 && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (prev && !mdc) falls++;
            prev = mdc;
        end
        v0 = mdio_o;
        @(negedge clk);
        v1 = mdio_o;
        if (neg) chk(v0 == 1'b0 && v1 == 1'b0, tag, {62'h0, v0, v1}, 64'h0);
        else     chk(v0 == 1'b1 && v1 == 1'b0, tag, {62'h0, v0, v1}, 64'h2);
    endtask

    task automatic period_check(input int exp_p);
        logic prev;
        int p = 0, guard = 0;
        prev = mdc;
        while (!(!prev && mdc) && guard < 200) begin
            @(negedge clk); guard++;
            if (!(!prev && mdc)) prev = mdc;
        end
        prev = mdc;
        do begin
            @(negedge clk); p++;
            if (!prev && mdc) break;
            prev = mdc;
        end while (p < 200);
        chk(p == exp_p, "R8 MDC period", 64'(p), 64'(exp_p));
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int f0, guard;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 32'h0, "R1 reset register", 64'(v), 64'h0);
        end
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 R10 pins at reset", {62'h0, mdc, mdio_oe}, 64'h0);

        // Clause 22, div 2, early launch
        wr(2'd0, (32'd2 << 16) | 32'h2);
        rd(2'd0, v);
        chk(v == 32'h0002_0002, "R8 cfg readback", 64'(v), 64'h0002_0002);
        wr(2'd1, (32'd5 << 8) | 32'd3);
        push(mk(0, 1, 5'd5, 5'd3, 16'hA5C3), 0, 0, 16'h0, "R2 clause22 write");
        wr(2'd3, 32'h0000_A5C3);
        rd(2'd0, v);
        chk(v[2] == 1'b1, "R6 busy after launch", 64'(v[2]), 64'h1);
        edge_check(1'b1, "R9 early launch");
        period_check(4);
        wr(2'd1, 32'h8000 | (32'd9 << 8) | 32'd7);
        rd(2'd1, v);
        chk(v == ((32'd5 << 8) | 32'd3), "R6 control held while busy", 64'(v), 64'h503);
        // hammer the data word through the completion edge
        f0 = frames_done;
        guard = 0;
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 32'h1111; bus_wr = 1'b1;
        while (frames_done == f0 && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (2) @(negedge clk);
        bus_wr = 1'b0;
        rd(2'd0, v);
        chk(v[2] == 1'b0, "R6 busy cleared at completion", 64'(v[2]), 64'h0);
        rd(2'd3, v);
        chk(v == 32'h0000_A5C3, "R6 data held through completion", 64'(v), 64'hA5C3);
        repeat (20) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);

        // Clause 22 read
        push(mk(0, 2, 5'd1, 5'd2, 16'h0), 1, 1, 16'hBEEF, "R3 clause22 read");
        wr(2'd1, 32'h8000 | (32'd1 << 8) | 32'd2);
        wait_idle();
        rd(2'd3, v);
        chk(v == 32'h0000_BEEF, "R3 read data", 64'(v), 64'hBEEF);
        rd(2'd0, v);
        chk(v[3] == 1'b0, "R7 no error on answered read", 64'(v[3]), 64'h0);

        // Clause 22 address write does nothing on the wire
        wr(2'd2, 32'h0000_1234);
        repeat (30) @(negedge clk);
        rd(2'd0, v);
        chk(v[2] == 1'b0 && mdio_oe == 1'b0, "R5 no launch", {62'h0, v[2], mdio_oe}, 64'h0);
        rd(2'd2, v);
        chk(v == 32'h0000_1234, "R5 address stored", 64'(v), 64'h1234);

        // Clause 45, late launch
        wr(2'd0, (32'd2 << 16) | 32'h1);
        wr(2'd1, (32'd31 << 8) | 32'd1);
        push(mk(1, 0, 5'd31, 5'd1, 16'h8001), 0, 0, 16'h0, "R4 clause45 address");
        wr(2'd2, 32'h0000_8001);
        edge_check(1'b0, "R9 late launch");
        wait_idle();
        push(mk(1, 1, 5'd31, 5'd1, 16'h0F0F), 0, 0, 16'h0, "R4 clause45 write");
        wr(2'd3, 32'h0000_0F0F);
        wait_idle();
        push(mk(1, 2, 5'd31, 5'd1, 16'h0), 1, 1, 16'h1357, "R4 clause45 read");
        wr(2'd1, 32'h8000 | (32'd31 << 8) | 32'd1);
        wait_idle();
        rd(2'd3, v);
        chk(v == 32'h0000_1357, "R4 clause45 read data", 64'(v), 64'h1357);

        // read with no responder
        push(mk(1, 2, 5'd4, 5'd6, 16'h0), 1, 0, 16'h0, "R7 unanswered read frame");
        wr(2'd1, 32'h8000 | (32'd4 << 8) | 32'd6);
        wait_idle();
        rd(2'd0, v);
        chk(v[3] == 1'b1, "R7 error flag set", 64'(v[3]), 64'h1);
        rd(2'd3, v);
        chk(v == 32'h0000_FFFF, "R7 data all ones", 64'(v), 64'hFFFF);
        push(mk(1, 2, 5'd4, 5'd6, 16'h0), 1, 1, 16'h00A0, "R7 answered read frame");
        wr(2'd1, 32'h8000 | (32'd4 << 8) | 32'd6);
        wait_idle();
        rd(2'd0, v);
        chk(v[3] == 1'b0, "R7 error flag cleared", 64'(v[3]), 64'h0);
        rd(2'd3, v);
        chk(v == 32'h0000_00A0, "R7 data after recovery", 64'(v), 64'hA0);

        // divider zero stalls the frame
        wr(2'd0, 32'h2);
        wr(2'd1, (32'd2 << 8) | 32'd4);
        push(mk(0, 1, 5'd2, 5'd4, 16'h0042), 0, 0, 16'h0, "R8 frame after stall");
        wr(2'd3, 32'h0000_0042);
        repeat (40) @(negedge clk);
        rd(2'd0, v);
        chk(mdc == 1'b0 && v[2] == 1'b1, "R8 MDC held with zero divider", {62'h0, mdc, v[2]}, 64'h1);
        wr(2'd0, (32'd3 << 16) | 32'h2);
        wait_idle();

        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R2 all frames seen", 64'(q.size()), 64'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule